// File: doc/BRIEF.md
# Keyboard scan-code wake detector

This block listens, without driving anything, to the clock and data lines of a PS/2-style keyboard. It waits until the keyboard clock has been high for a qualified idle window. It then captures one 11-bit frame on the falling edges of that clock and checks the frame's odd parity and its stop bit. The data byte is compared against a programmed scan code.

When a frame matches, a sticky wake status flag is raised. Software clears the flag by writing a one to it. While the flag and its enable are both set, the event output drives a level whose polarity is programmable. Frames that do not match are dropped without notice, and the detector looks for the next idle window. The block runs from the standby clock and is reset only by the standby power-on reset. Timing is measured with a one-microsecond tick from the system.

Top module: `kbd_wake_det`

## Requirements
- R1: The raw keyboard lines pass through a two-stage synchronizer. The wake status rises on the third rising system-clock edge after the keyboard clock input falls for the stop bit of a matching frame.
- R2: A frame can start only at a falling keyboard-clock edge that follows at least IDLE_MIN_US (default 115) microsecond ticks of the clock held high. An edge after a shorter high time is ignored.
- R3: The data sampled at the qualifying edge is the start bit and must be 0. If it is 1, the edge is ignored and no frame starts.
- R4: The frame is sampled one bit per falling edge, in this order: start, data bits 0 to 7 (least significant first), parity, stop. The data byte is compared with scan_code_i bit for bit.
- R5: A frame sets the status when three conditions hold: the byte equals scan_code_i, the byte plus the parity bit hold an odd number of ones, and the stop bit is 1.
- R6: A frame with even parity, a different byte, or a stop bit of 0 leaves the status unchanged. The detector then waits for the next idle window.
- R7: Inside a frame, a keyboard-clock high time of more than IDLE_MAX_US (default 145) ticks abandons the frame. A later qualified frame is still recognized.
- R8: The status is sticky. A one-cycle pulse on sts_clr_i clears it at the next clock edge. If a match and a clear fall in the same cycle, the match wins.
- R9: While the status and wake_en_i are both 1, evt_o equals evt_pol_i. Otherwise evt_o equals the inverse of evt_pol_i.
- R10: rst_ni (active low, asynchronous) clears the status and the frame state. Nothing else resets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Standby system clock |
| rst_ni | input | 1 | Standby power-on reset, active low, asynchronous |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| kbd_clk_i | input | 1 | Raw keyboard clock line |
| kbd_dat_i | input | 1 | Raw keyboard data line |
| scan_code_i | input | DATA_W | Programmed wake scan code |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the status |
| wake_en_i | input | 1 | Event enable |
| evt_pol_i | input | 1 | Active level of evt_o |
| wake_sts_o | output | 1 | Sticky wake status |
| evt_o | output | 1 | Wake event level |

## Verification
The keyboard lines are driven one time step after a rising edge, so they pass two synchronizer flops before the frame logic acts. The status therefore changes at the third rising edge after the stop-bit falling transition. The bench checks it at the falling edges just before and just after that third edge. A clear takes effect at the first rising edge after the strobe, and evt_o follows its inputs within the same cycle, so both are checked at the next falling edge. A behavioural model delays the raw lines by the same number of edges and is compared with both outputs at every falling clock edge.

// File: rtl/kbd_wake_pkg.sv
package kbd_wake_pkg;
  typedef enum logic {RX_IDLE, RX_BITS} rx_state_e;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '1;
      prev_q <= '1;
    end else begin
      stg_q  <= {stg_q[STAGES-2:0], raw_i};
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  for (genvar l = 0; l < W; l++) begin : g_lane
    assign fall_o[l] = prev_q[l] & ~sync_o[l];
  end
endmodule

// File: rtl/kbd_idle_timer.sv
module kbd_idle_timer #(
  parameter int unsigned MAX_US = 145,
  parameter int unsigned CW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  output logic [CW-1:0] cnt_o
);
  // saturates one above the gap limit so "too long" stays visible
  localparam logic [CW-1:0] SAT = CW'(MAX_US + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!line_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_wake_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IDLE_MIN_US = 115,
  parameter int unsigned IDLE_MAX_US = 145,
  parameter int unsigned CW          = 8,
  parameter int unsigned BW          = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              dat_i,
  input  logic [CW-1:0]     hi_cnt_i,
  input  logic [DATA_W-1:0] code_i,
  output logic              hit_o,
  output logic              busy_o,
  output logic [BW-1:0]     bit_cnt_o
);
  localparam int unsigned PAR_IDX = DATA_W + 1;
  localparam int unsigned LAST    = DATA_W + 2;

  rx_state_e         state_q;
  logic [BW-1:0]     cnt_q;
  logic [DATA_W-1:0] shr_q;
  logic              par_q;
  logic              qual, gap;

  assign qual = hi_cnt_i >= CW'(IDLE_MIN_US);
  assign gap  = hi_cnt_i >  CW'(IDLE_MAX_US);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (fall_i && qual && !dat_i) begin
            state_q <= RX_BITS;
            cnt_q   <= BW'(1);
          end
        end
        RX_BITS: begin
          if (gap) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else if (fall_i) begin
            if (cnt_q <= BW'(DATA_W))        shr_q <= {dat_i, shr_q[DATA_W-1:1]};
            else if (cnt_q == BW'(PAR_IDX)) par_q <= dat_i;
            if (cnt_q == BW'(LAST)) begin
              state_q <= RX_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // stop bit is the live sample on the last edge
  assign hit_o = (state_q == RX_BITS) && !gap && fall_i && (cnt_q == BW'(LAST)) &&
                 dat_i && (shr_q == code_i) && (^{shr_q, par_q});

  assign busy_o    = (state_q == RX_BITS);
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/kbd_wake_det.sv
module kbd_wake_det
  import kbd_wake_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IDLE_MIN_US = 115,
  parameter int unsigned IDLE_MAX_US = 145
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_us_i,
  input  logic              kbd_clk_i,
  input  logic              kbd_dat_i,
  input  logic [DATA_W-1:0] scan_code_i,
  input  logic              sts_clr_i,
  input  logic              wake_en_i,
  input  logic              evt_pol_i,
  output logic              wake_sts_o,
  output logic              evt_o
);
  localparam int unsigned FRAME_BITS = DATA_W + 3;
  localparam int unsigned BW         = $clog2(FRAME_BITS);
  localparam int unsigned CW         = $clog2(IDLE_MAX_US + 2);

  logic [1:0]        line_s, line_fall;
  logic [CW-1:0]     hi_cnt;
  logic              rx_hit, rx_busy;
  logic [BW-1:0]     rx_bit_cnt;
  logic              sts_q;

  kbd_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({kbd_dat_i, kbd_clk_i}),
    .sync_o (line_s),
    .fall_o (line_fall)
  );

  kbd_idle_timer #(.MAX_US(IDLE_MAX_US), .CW(CW)) i_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_us_i),
    .line_i (line_s[0]),
    .cnt_o  (hi_cnt)
  );

  kbd_frame_rx #(
    .DATA_W      (DATA_W),
    .IDLE_MIN_US (IDLE_MIN_US),
    .IDLE_MAX_US (IDLE_MAX_US),
    .CW          (CW),
    .BW          (BW)
  ) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (line_fall[0]),
    .dat_i     (line_s[1]),
    .hi_cnt_i  (hi_cnt),
    .code_i    (scan_code_i),
    .hit_o     (rx_hit),
    .busy_o    (rx_busy),
    .bit_cnt_o (rx_bit_cnt)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else         sts_q <= rx_hit | (sts_q & ~sts_clr_i);
  end

  assign wake_sts_o = sts_q;
  assign evt_o      = (sts_q & wake_en_i) ? evt_pol_i : ~evt_pol_i;
endmodule

// File: rtl/kbd_wake_det_chk.sv
module kbd_wake_det_chk #(
  parameter int unsigned BW   = 4,
  parameter int unsigned LAST = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sts_clr_i,
  input logic          wake_en_i,
  input logic          evt_pol_i,
  input logic          wake_sts_o,
  input logic          evt_o,
  input logic          hit_i,
  input logic          fall_i,
  input logic          busy_i,
  input logic [BW-1:0] bit_cnt_i
);
  p_evt_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_sts_o && wake_en_i) |-> (evt_o == evt_pol_i));

  p_evt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_sts_o && wake_en_i) |-> (evt_o != evt_pol_i));

  p_sts_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_sts_o && !sts_clr_i) |=> wake_sts_o);

  p_sts_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i && !hit_i) |=> !wake_sts_o);

  p_set_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> wake_sts_o);

  p_rise_needs_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_sts_o) |-> $past(hit_i));

  p_hit_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (fall_i && busy_i));

  p_bit_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (bit_cnt_i >= BW'(1) && bit_cnt_i <= BW'(LAST)));
endmodule

bind kbd_wake_det kbd_wake_det_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sts_clr_i  (sts_clr_i),
  .wake_en_i  (wake_en_i),
  .evt_pol_i  (evt_pol_i),
  .wake_sts_o (wake_sts_o),
  .evt_o      (evt_o),
  .hit_i      (rx_hit),
  .fall_i     (line_fall[0]),
  .busy_i     (rx_busy),
  .bit_cnt_i  (rx_bit_cnt)
);

// File: tb/test_kbd_wake_det.sv
module test_kbd_wake_det;
  localparam int US_CYC  = 4;
  localparam int HALF_US = 20;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       kclk = 1'b1, kdat = 1'b1, clr = 1'b0, en = 1'b0, pol = 1'b1;
  logic [7:0] scan = 8'h29;
  logic       sts, evt;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  kbd_wake_det i_kbd_wake_det (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_us_i   (tick),
    .kbd_clk_i   (kclk),
    .kbd_dat_i   (kdat),
    .scan_code_i (scan),
    .sts_clr_i   (clr),
    .wake_en_i   (en),
    .evt_pol_i   (pol),
    .wake_sts_o  (sts),
    .evt_o       (evt)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk);
      #1;
      tick = (c == US_CYC - 1);
      c = (c + 1) % US_CYC;
    end
  end

  // behavioural reference: raw lines seen two edges late, microsecond high timer
  int q_c[$] = '{1, 1, 1};
  int q_d[$] = '{1, 1, 1};
  int m_hi = 0, m_state = 0, m_bit = 0, m_byte = 0, m_par = 0;
  bit m_sts = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_c = '{1, 1, 1};
      q_d = '{1, 1, 1};
      m_hi = 0; m_state = 0; m_bit = 0; m_byte = 0; m_par = 0; m_sts = 1'b0;
    end else begin
      int cur, prv, dcur;
      bit fall, hit;
      q_c.push_back(int'(kclk));
      q_d.push_back(int'(kdat));
      prv  = q_c[0];
      cur  = q_c[1];
      dcur = q_d[1];
      void'(q_c.pop_front());
      void'(q_d.pop_front());
      fall = (prv == 1) && (cur == 0);
      hit  = 1'b0;
      if (m_state == 0) begin
        if (fall && m_hi >= 115 && dcur == 0) begin
          m_state = 1; m_bit = 1; m_byte = 0;
        end
      end else if (m_hi > 145) begin
        m_state = 0;
      end else if (fall) begin
        if (m_bit <= 8) m_byte = m_byte | (dcur << (m_bit - 1));
        else if (m_bit == 9) m_par = dcur;
        else begin
          hit = (m_byte == int'(scan)) && (($countones(m_byte) + m_par) % 2 == 1) && (dcur == 1);
          m_state = 0;
        end
        m_bit++;
      end
      if (cur == 0) m_hi = 0;
      else if (tick && m_hi < 146) m_hi++;
      if (hit) m_sts = 1'b1;
      else if (clr) m_sts = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sts, m_sts, cur_req, "model status");
      check(evt, (m_sts && en) ? pol : !pol, cur_req, "model event");
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_us(input int n);
    wait_cyc(n * US_CYC);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit stop,
                            input bit start, input int idle_us, input int abort_after,
                            input bit chk_lat, input string lat_req);
    logic [10:0] bits;
    bits = {stop, (~^b) ^ bad_par, b, start};
    wait_us(idle_us);
    for (int i = 0; i < 11; i++) begin
      kdat = bits[i];
      wait_us(HALF_US);
      kclk = 1'b0;
      if (i == 10 && chk_lat) begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(sts, 1'b0, lat_req, "status before third edge");
        @(posedge clk); @(negedge clk);
        check(sts, 1'b1, lat_req, "status at third edge");
        wait_cyc(HALF_US * US_CYC - 3);
      end else begin
        wait_us(HALF_US);
      end
      kclk = 1'b1;
      if (i == abort_after) wait_us(200);
    end
    kdat = 1'b1;
  endtask

  task automatic pulse_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(sts, 1'b0, "R10", "status after reset");
    check(evt, 1'b0, "R10", "event after reset");

    en = 1'b1;
    cur_req = "R5";
    send_frame(8'h29, 0, 1, 0, 140, -1, 1, "R1");
    wait_us(5);
    check(sts, 1'b1, "R5", "matching frame sets status");
    check(evt, 1'b1, "R9", "event active high");
    @(negedge clk) pol = 1'b0;
    @(negedge clk) check(evt, 1'b0, "R9", "event active low");
    pol = 1'b1;

    cur_req = "R8";
    wait_us(100);
    check(sts, 1'b1, "R8", "status sticky");
    pulse_clear();
    @(negedge clk) check(sts, 1'b0, "R8", "write one clears");

    cur_req = "R6";
    send_frame(8'h29, 1, 1, 0, 140, -1, 0, "R6");
    wait_us(5);
    check(sts, 1'b0, "R6", "even parity rejected");
    send_frame(8'h2a, 0, 1, 0, 140, -1, 0, "R6");
    wait_us(5);
    check(sts, 1'b0, "R6", "other byte rejected");
    send_frame(8'h29, 0, 0, 0, 140, -1, 0, "R6");
    wait_us(5);
    check(sts, 1'b0, "R6", "stop bit 0 rejected");

    cur_req = "R2";
    send_frame(8'h29, 0, 1, 0, 40, -1, 0, "R2");
    wait_us(5);
    check(sts, 1'b0, "R2", "short idle ignored");

    cur_req = "R4";
    @(negedge clk) scan = 8'h83;
    send_frame(8'hc1, 0, 1, 0, 140, -1, 0, "R4");
    wait_us(5);
    check(sts, 1'b0, "R4", "reversed bit order rejected");
    send_frame(8'h83, 0, 1, 0, 140, -1, 0, "R4");
    wait_us(5);
    check(sts, 1'b1, "R4", "lsb-first byte matched");
    pulse_clear();
    @(negedge clk) scan = 8'h29;

    cur_req = "R3";
    send_frame(8'h29, 0, 1, 1, 140, -1, 0, "R3");
    wait_us(5);
    check(sts, 1'b0, "R3", "start bit 1 ignored");

    cur_req = "R7";
    send_frame(8'h29, 0, 1, 0, 140, 4, 0, "R7");
    wait_us(5);
    check(sts, 1'b0, "R7", "long gap aborts frame");
    send_frame(8'h29, 0, 1, 0, 140, -1, 0, "R7");
    wait_us(5);
    check(sts, 1'b1, "R7", "detector rearmed after abort");
    pulse_clear();

    cur_req = "R8";
    @(negedge clk) clr = 1'b1;
    send_frame(8'h29, 0, 1, 0, 140, -1, 1, "R8");
    wait_us(5);
    check(sts, 1'b0, "R8", "held clear removes status after set");
    @(negedge clk) clr = 1'b0;

    cur_req = "R9";
    send_frame(8'h29, 0, 1, 0, 140, -1, 0, "R9");
    wait_us(5);
    @(negedge clk) en = 1'b0;
    @(negedge clk) check(evt, 1'b0, "R9", "disabled event inactive high pol");
    pol = 1'b0;
    @(negedge clk) check(evt, 1'b1, "R9", "disabled event inactive low pol");
    check(sts, 1'b1, "R9", "status kept while disabled");

    cur_req = "R10";
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) check(sts, 1'b0, "R10", "reset clears status");
    rst_n = 1'b1;
    @(negedge clk) check(sts, 1'b0, "R10", "status stays clear");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule